// File: doc/BRIEF.md
# Pointer-indexed UART mode register pair

This block keeps the two mode registers of a single UART channel. Both registers answer at one bus location. An internal pointer chooses which of the two is reached. After a hardware reset the pointer selects the first register. The first complete access to the mode location, whether a read or a write, moves the pointer to the second register. From then on every access reaches the second register, until software writes the pointer-reset command to the channel command location.

The CPU side uses a synchronous register port. It has a chip select, read and write strobes that may be held for one or more clock cycles, separate address-match inputs for the mode location and for the command location, and byte-wide write and read data. Both register contents leave the block continuously, so the rest of the channel can decode the fields it needs. The pointer moves only when a mode access ends. Because of that, every cycle of an ongoing access uses the same register.

Top module: `uart_mode_pair`

## Requirements
- R1: After reset both mode outputs are 0x00 and the pointer selects the first register.
- R2: While the pointer selects the first register, a mode write loads `wdata` into the first register only and leaves the second unchanged.
- R3: The end of a mode access (read or write) made while the pointer selects the first register moves the pointer to the second register. The move takes effect on the clock edge after the strobe drops.
- R4: Once the pointer selects the second register, it keeps doing so through any number of further mode reads and writes. Mode writes then load only the second register.
- R5: A command write whose bits 7:4 equal 4'b0001 returns the pointer to the first register when the write strobe ends.
- R6: A command write with any other value in bits 7:4 leaves the pointer where it is.
- R7: During a mode read, `rdata` shows the register the pointer selects. At all other times `rdata` is 0x00.
- R8: A strobe without chip select, or without a matching address, changes neither register nor the pointer.
- R9: While a strobe is held for several cycles, the pointer does not move. A held mode read or write uses one register for its whole duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| hit_mode | input | 1 | Address matches the mode location |
| hit_cmd | input | 1 | Address matches the command location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| mode_a | output | 8 | First mode register contents |
| mode_b | output | 8 | Second mode register contents |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, the command code in bits 7:4, and 4'b0001 as the pointer-reset code. These values make every code value reachable in random command writes. With 1-in-16 odds, random data hits the pointer-reset code and the other codes often enough to exercise both outcomes. Strobe lengths from one to four cycles expose any pointer move in the middle of an access. Stray strobes, without chip select or without an address match, are mixed in to show that they touch nothing.

// File: rtl/uart_mode_pair.sv
module uart_mode_pair #(
  parameter int DATA_W     = 8,
  parameter int CODE_LSB   = 4,
  parameter int CODE_W     = 4,
  parameter int RESET_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              hit_mode,
  input  logic              hit_cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode_a,
  output logic [DATA_W-1:0] mode_b
);
  localparam logic [CODE_W-1:0] PTR_CODE = CODE_W'(RESET_CODE);

  logic              mode_acc, mode_wr, mode_rd, cmd_wr;
  logic              mode_acc_q, cmd_wr_q;
  logic              mode_end, cmd_end;
  logic [CODE_W-1:0] code_q;
  logic              sel_second;

  assign mode_acc = sel & hit_mode & (rd_en | wr_en);
  assign mode_wr  = sel & hit_mode & wr_en;
  assign mode_rd  = sel & hit_mode & rd_en;
  assign cmd_wr   = sel & hit_cmd & wr_en;
  assign mode_end = mode_acc_q & ~mode_acc;
  assign cmd_end  = cmd_wr_q & ~cmd_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_acc_q <= 1'b0;
      cmd_wr_q   <= 1'b0;
      code_q     <= '0;
    end else begin
      mode_acc_q <= mode_acc;
      cmd_wr_q   <= cmd_wr;
      if (cmd_wr) code_q <= wdata[CODE_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             sel_second <= 1'b0;
    else if (cmd_end && code_q == PTR_CODE) sel_second <= 1'b0;
    else if (mode_end)                      sel_second <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a <= '0;
      mode_b <= '0;
    end else if (mode_wr) begin
      if (sel_second) mode_b <= wdata;
      else            mode_a <= wdata;
    end
  end

  assign rdata = mode_rd ? (sel_second ? mode_b : mode_a) : '0;
endmodule

// File: rtl/uart_mode_pair_chk.sv
module uart_mode_pair_chk #(
  parameter int DATA_W     = 8,
  parameter int CODE_LSB   = 4,
  parameter int CODE_W     = 4,
  parameter int RESET_CODE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic              hit_mode,
  input logic              hit_cmd,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] mode_a,
  input logic [DATA_W-1:0] mode_b,
  input logic              ptr
);
  logic              c_acc, c_cmd, c_acc_q, c_cmd_q;
  logic [CODE_W-1:0] c_code;
  logic              c_mend, c_cend, c_hit_code;

  assign c_acc      = sel && hit_mode && (rd_en || wr_en);
  assign c_cmd      = sel && hit_cmd && wr_en;
  assign c_mend     = c_acc_q && !c_acc;
  assign c_cend     = c_cmd_q && !c_cmd;
  assign c_hit_code = (c_code == CODE_W'(RESET_CODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_acc_q <= 1'b0;
      c_cmd_q <= 1'b0;
      c_code  <= '0;
    end else begin
      c_acc_q <= c_acc;
      c_cmd_q <= c_cmd;
      if (c_cmd) c_code <= wdata[CODE_LSB +: CODE_W];
    end
  end

  AST_PTR_HOLD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && c_acc_q && !c_cend) |=> $stable(ptr)); // R9
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mend && !(c_cend && c_hit_code)) |=> ptr); // R3
  AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr && !(c_cend && c_hit_code)) |=> ptr); // R4
  AST_PTR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cend && c_hit_code) |=> !ptr); // R5
  AST_OTHER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cend && !c_hit_code && !c_mend && !c_acc_q) |=> $stable(ptr)); // R6
  AST_SECOND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr) |=> $stable(mode_b)); // R2
  AST_STRAY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && hit_mode && wr_en) |=> ($stable(mode_a) && $stable(mode_b))); // R8
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && hit_mode && rd_en) |-> (rdata == '0)); // R7
endmodule

bind uart_mode_pair uart_mode_pair_chk #(
  .DATA_W(DATA_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W), .RESET_CODE(RESET_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
  .hit_mode(hit_mode), .hit_cmd(hit_cmd), .wdata(wdata), .rdata(rdata),
  .mode_a(mode_a), .mode_b(mode_b), .ptr(sel_second)
);

// File: tb/sim_uart_mode_pair.sv
module sim_uart_mode_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic       hit_mode = 1'b0, hit_cmd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, mode_a, mode_b;

  int total = 0;
  int bad = 0;
  logic       exp_ptr = 1'b0;
  logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

  always #10 clk = ~clk;

  uart_mode_pair u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .hit_mode(hit_mode), .hit_cmd(hit_cmd), .wdata(wdata),
    .rdata(rdata), .mode_a(mode_a), .mode_b(mode_b)
  );

  function automatic logic [7:0] exp_selected();
    return exp_ptr ? exp_b : exp_a;
  endfunction

  function automatic logic exp_cmd_restores(input logic [7:0] d);
    return d[7:4] == 4'b0001;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, mode_a, exp_a);
    check(req, mode_b, exp_b);
    check("R7", rdata, 8'h00);
  endtask

  task automatic idle_bus();
    sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0; hit_mode = 1'b0; hit_cmd = 1'b0;
  endtask

  task automatic mode_access(input logic is_wr, input logic [7:0] d, input int len);
    @(negedge clk);
    sel = 1'b1; hit_mode = 1'b1; rd_en = !is_wr; wr_en = is_wr; wdata = d;
    for (int i = 0; i < len; i++) begin
      #1;
      if (!is_wr) check(exp_ptr ? "R4" : "R7", rdata, exp_selected());
      @(negedge clk);
      if (is_wr && i == len - 1) begin
        if (exp_ptr) exp_b = d; else exp_a = d;
      end
      if (is_wr) check(exp_ptr ? "R4" : "R9", exp_ptr ? mode_b : mode_a, d);
    end
    idle_bus();
    @(negedge clk);
    exp_ptr = 1'b1;
    check_regs("R2");
  endtask

  task automatic cmd_write(input logic [7:0] d, input int len);
    @(negedge clk);
    sel = 1'b1; hit_cmd = 1'b1; wr_en = 1'b1; wdata = d;
    repeat (len) @(negedge clk);
    idle_bus();
    @(negedge clk);
    if (exp_cmd_restores(d)) exp_ptr = 1'b0;
    check_regs(exp_cmd_restores(d) ? "R5" : "R6");
  endtask

  task automatic stray(input int kind, input logic [7:0] d);
    @(negedge clk);
    wdata = d; wr_en = 1'b1; rd_en = kind[0];
    if (kind < 2) begin sel = 1'b0; hit_mode = 1'b1; end
    else          begin sel = 1'b1; hit_mode = 1'b0; hit_cmd = 1'b0; end
    #1 check("R8", rdata, 8'h00);
    @(negedge clk);
    idle_bus();
    @(negedge clk);
    check_regs("R8");
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    // directed: first write hits register 1 only, then sticks at 2
    mode_access(1'b1, 8'hA5, 1);
    check("R2", mode_a, 8'hA5);
    check("R2", mode_b, 8'h00);
    mode_access(1'b0, 8'h00, 1);
    mode_access(1'b1, 8'h3C, 1);
    mode_access(1'b1, 8'h77, 1);
    check("R4", mode_b, 8'h77);
    check("R4", mode_a, 8'hA5);
    cmd_write(8'h2F, 1);
    mode_access(1'b0, 8'h00, 1);
    cmd_write(8'h10, 1);
    mode_access(1'b0, 8'h00, 3);
    cmd_write(8'h1F, 2);
    mode_access(1'b1, 8'hC3, 4);
    mode_access(1'b0, 8'h00, 2);
    stray(0, 8'hFF);
    stray(2, 8'h11);

    // reset mid-life returns everything to the reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_ptr = 1'b0; exp_a = 8'h00; exp_b = 8'h00;
    @(negedge clk);
    check_regs("R1");
    mode_access(1'b0, 8'h00, 1);

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      int len = $urandom_range(1, 4);
      if (op < 3)      mode_access(1'b1, d, len);
      else if (op < 5) mode_access(1'b0, d, len);
      else if (op < 6) cmd_write({4'b0001, d[3:0]}, len);
      else if (op < 8) cmd_write(d, len);
      else             stray($urandom_range(0, 3), d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule